// File: doc/BRIEF.md
# Dual-Bank Byte-Mapped GPIO Controller

This block gives software control of a set of general-purpose pins through a small byte-wide register bus. The bus carries an address, write data with a write strobe, and a read strobe with registered read data. The pins are split at a parameterised boundary into a low bank and a high bank. Each bank has its own copy of three per-pin registers: enable, direction and level. Each bank places eight pins in a byte. The high bank's registers sit 0x20 above the low bank's.

The controller drives a per-pin output-enable and output-value pair toward the pad ring. It also samples the pad inputs through a two-stage synchroniser. The level register depends on direction. For an output pin, it stores and returns the value the pin drives. For an input pin, it returns the synchronised pad value and ignores writes. An output level therefore cannot be loaded ahead of a switch to output: after the switch, the pin drives whatever level was last stored while it was an output.

Top module: `gpio_dual_bank`

## Requirements
- R1: Within a bank, the enable register occupies byte offsets 0x00–0x03, the direction register 0x04–0x07 and the level register 0x08–0x0B. Bank-relative pin k sits in byte k/8 at bit k%8.
- R2: Pins with index at or above SPLIT belong to the high bank and are renumbered from zero there. Address bit 5 set (base 0x20) selects the high bank's registers.
- R3: Reset (synchronous, active high) has these effects. Every pin becomes an input (direction bit 1). Stored levels clear to 0. pin_oe and pin_out go to 0. Enable bits take EN_RESET, which by default enables pins 0–6 and 10–12 and disables pins 7, 8, 9 and 13.
- R4: Direction bit 1 means input and 0 means output. pin_oe[i] is 1 exactly when pin i is enabled and an output. pin_oe and pin_out change on the second clock edge after the write strobe is sampled.
- R5: A level write leaves the stored level of any pin that is currently an input unchanged.
- R6: A level read returns the stored level for an enabled output pin. For an enabled input pin it returns the pad value after a two-flop synchroniser, so a pad change becomes visible no earlier than a read strobe sampled two edges after the change.
- R7: When a pin turns from input to output, it drives the level it stored while it was last an output, until a new level is written.
- R8: A disabled pin never asserts pin_oe or pin_out, and its level bit reads as 0.
- R9: Bits for pin positions beyond a bank's pin count read 0 and ignore writes. Reads of byte offsets 0x0C–0x1F, or of bytes beyond a bank's byte count, return 0, and writes there change nothing.
- R10: rd_data is loaded on the clock edge that samples rd_en and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Register byte address; bit 5 selects the high bank |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Pad input values (asynchronous) |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |

## Verification
Direction patterns mix inputs and outputs inside one byte, so a level write with all ones shows whether only the output bits took the value. Re-running a pin from output to input and back separates a design that drops the stored level from one that keeps it. The pads are driven all high with the enable pattern from reset, which tells the enable gating apart from the direction mux and shows the disabled pins 7–9 and 13 reading zero. A read issued right after a pad change sees the old value and a second read sees the new one, which pins the synchroniser depth at two. Accesses to the high bank, to the gap offsets and to bytes past each bank's end show that the two banks decode apart.

// File: rtl/gpio_dual_bank_pkg.sv
package gpio_dual_bank_pkg;

  localparam int ADDR_W   = 6;
  localparam int BANK_BIT = 5;

  typedef enum logic [1:0] {
    KIND_EN   = 2'd0,
    KIND_DIR  = 2'd1,
    KIND_LVL  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  function automatic int bytes_for(input int pins);
    return (pins + 7) / 8;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_dual_bank_pkg::*;
#(
  parameter int LO_BYTES = 2,
  parameter int HI_BYTES = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank_hi,
  output reg_kind_e         kind,
  output logic [1:0]        byte_idx,
  output logic              hit
);

  logic [4:0] off;
  int         limit;

  always_comb begin
    off      = addr[4:0];
    bank_hi  = addr[BANK_BIT];
    byte_idx = off[1:0];
    unique case (off[4:2])
      3'd0:    kind = KIND_EN;
      3'd1:    kind = KIND_DIR;
      3'd2:    kind = KIND_LVL;
      default: kind = KIND_NONE;
    endcase
    limit = bank_hi ? HI_BYTES : LO_BYTES;
    hit   = (kind != KIND_NONE) && (int'(byte_idx) < limit);
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_dual_bank_pkg::*;
#(
  parameter int              PINS        = 8,
  parameter logic [PINS-1:0] EN_INIT     = '1,
  parameter int              SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_kind_e       kind,
  input  logic [1:0]      byte_idx,
  input  logic [7:0]      wr_data,
  input  logic [PINS-1:0] pin_in,
  output logic [7:0]      rd_byte,
  output logic [PINS-1:0] oe_nxt,
  output logic [PINS-1:0] out_nxt
);

  localparam int BYTES = bytes_for(PINS);
  localparam int PADW  = BYTES * 8;

  logic [PINS-1:0] en_q, dir_q, lvl_q, pin_sync, lvl_view;
  logic [PADW-1:0] pad_sel;

  gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= EN_INIT;
      dir_q <= '1;
      lvl_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < PINS; i++) begin
        if (int'(byte_idx) == i / 8) begin
          case (kind)
            KIND_EN:  en_q[i]  <= wr_data[i % 8];
            KIND_DIR: dir_q[i] <= wr_data[i % 8];
            KIND_LVL: if (!dir_q[i]) lvl_q[i] <= wr_data[i % 8];
            default:  ;
          endcase
        end
      end
    end
  end

  always_comb begin
    lvl_view = en_q & ((dir_q & pin_sync) | (~dir_q & lvl_q));
    pad_sel  = '0;
    case (kind)
      KIND_EN:  pad_sel[PINS-1:0] = en_q;
      KIND_DIR: pad_sel[PINS-1:0] = dir_q;
      KIND_LVL: pad_sel[PINS-1:0] = lvl_view;
      default:  ;
    endcase
    rd_byte = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (int'(byte_idx) == b) rd_byte = pad_sel[b*8 +: 8];
    end
    oe_nxt  = en_q & ~dir_q;
    out_nxt = en_q & ~dir_q & lvl_q;
  end

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_bank_pkg::*;
#(
  parameter int                  NUM_PINS    = 14,
  parameter int                  SPLIT       = 10,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] EN_RESET    = 14'h1C7F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [5:0]          addr,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  output logic [7:0]          rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);

  localparam int LO_PINS  = SPLIT;
  localparam int HI_PINS  = NUM_PINS - SPLIT;
  localparam int LO_BYTES = bytes_for(LO_PINS);
  localparam int HI_BYTES = bytes_for(HI_PINS);

  logic          bank_hi, hit;
  reg_kind_e     kind;
  logic [1:0]    byte_idx;
  logic [7:0]    lo_rd, hi_rd, rd_nxt;
  logic [LO_PINS-1:0] lo_oe, lo_out;
  logic [HI_PINS-1:0] hi_oe, hi_out;

  gpio_addr_decode #(.LO_BYTES(LO_BYTES), .HI_BYTES(HI_BYTES)) u_dec (
    .addr     (addr),
    .bank_hi  (bank_hi),
    .kind     (kind),
    .byte_idx (byte_idx),
    .hit      (hit)
  );

  gpio_pin_bank #(
    .PINS(LO_PINS), .EN_INIT(EN_RESET[LO_PINS-1:0]), .SYNC_STAGES(SYNC_STAGES)
  ) u_lo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en && hit && !bank_hi),
    .kind     (kind),
    .byte_idx (byte_idx),
    .wr_data  (wr_data),
    .pin_in   (pin_in[LO_PINS-1:0]),
    .rd_byte  (lo_rd),
    .oe_nxt   (lo_oe),
    .out_nxt  (lo_out)
  );

  gpio_pin_bank #(
    .PINS(HI_PINS), .EN_INIT(EN_RESET[NUM_PINS-1:SPLIT]), .SYNC_STAGES(SYNC_STAGES)
  ) u_hi (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en && hit && bank_hi),
    .kind     (kind),
    .byte_idx (byte_idx),
    .wr_data  (wr_data),
    .pin_in   (pin_in[NUM_PINS-1:SPLIT]),
    .rd_byte  (hi_rd),
    .oe_nxt   (hi_oe),
    .out_nxt  (hi_out)
  );

  always_comb begin
    if (!hit)        rd_nxt = '0;
    else if (bank_hi) rd_nxt = hi_rd;
    else             rd_nxt = lo_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      if (rd_en) rd_data <= rd_nxt;
      pin_oe  <= {hi_oe, lo_oe};
      pin_out <= {hi_out, lo_out};
    end
  end

endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk,
  input logic                rst,
  input logic [5:0]          addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [7:0]          rd_data,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out
);

  logic gap_off;
  assign gap_off = (addr[4:2] >= 3'd3);

  AST_OUT_WITHIN_OE: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0); // R8

  AST_RESET_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0)); // R3

  AST_GAP_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(gap_off)) |-> (rd_data == 8'h00)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data)); // R10

  AST_PINS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(wr_en, 2)) |-> ($stable(pin_oe) && $stable(pin_out))); // R4

endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .pin_oe  (pin_oe),
  .pin_out (pin_out)
);

// File: tb/gpio_dual_bank_test.sv
`timescale 1ns/1ps
module gpio_dual_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [13:0] pin_in = '0;
  logic [13:0] pin_oe, pin_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dual_bank uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pin_in = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(req, {8'h00, rd_data}, {8'h00, exp});
  endtask

  task automatic pins_chk(input string req, input logic [13:0] oe, input logic [13:0] o);
    @(negedge clk);
    chk({req, " oe"}, {2'b00, pin_oe}, {2'b00, oe});
    chk({req, " out"}, {2'b00, pin_out}, {2'b00, o});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R3 oe after reset", {2'b00, pin_oe}, 16'h0000);
    rd_chk("R3 R1 enable lo byte0", 6'h00, 8'h7F);
    rd_chk("R3 enable lo byte1", 6'h01, 8'h00);
    rd_chk("R3 R2 enable hi byte0", 6'h20, 8'h07);
    rd_chk("R3 direction lo byte0", 6'h04, 8'hFF);
    rd_chk("R3 R9 direction lo byte1", 6'h05, 8'h03);
    rd_chk("R3 R9 direction hi byte0", 6'h24, 8'h0F);
  endtask

  task automatic t_drive();
    do_reset();
    wr(6'h04, 8'hF0);
    wr(6'h08, 8'h05);
    pins_chk("R4 drive", 14'h000F, 14'h0005);
    rd_chk("R6 R1 level mixed", 6'h08, 8'h05);
    wr(6'h08, 8'hFF);
    pins_chk("R5 write all ones", 14'h000F, 14'h000F);
    rd_chk("R5 level readback", 6'h08, 8'h0F);
    wr(6'h04, 8'hF1);
    wr(6'h08, 8'h00);
    pins_chk("R5 input ignores", 14'h000E, 14'h0000);
    wr(6'h04, 8'hF0);
    pins_chk("R7 back to output", 14'h000F, 14'h0001);
  endtask

  task automatic t_sync();
    do_reset();
    pin_in = 14'h3FFF;
    repeat (2) @(negedge clk);
    rd_chk("R6 R8 input lo byte0", 6'h08, 8'h7F);
    rd_chk("R8 input lo byte1", 6'h09, 8'h00);
    rd_chk("R8 R2 input hi byte0", 6'h28, 8'h07);
    wr(6'h01, 8'h01);
    rd_chk("R8 enable pin8", 6'h09, 8'h01);
    @(negedge clk); pin_in = '0;
    rd_chk("R6 sync not yet", 6'h08, 8'h7F);
    rd_chk("R6 sync settled", 6'h08, 8'h00);
  endtask

  task automatic t_high_bank();
    do_reset();
    wr(6'h24, 8'h00);
    wr(6'h28, 8'h0F);
    pins_chk("R2 high bank drive", 14'h1C00, 14'h1C00);
    rd_chk("R2 R8 high level", 6'h28, 8'h07);
    rd_chk("R2 low untouched", 6'h04, 8'hFF);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(6'h04, 8'h00);
    wr(6'h08, 8'h80);
    pins_chk("R8 pin7 disabled", 14'h007F, 14'h0000);
    rd_chk("R8 disabled level", 6'h08, 8'h00);
    wr(6'h00, 8'h7E);
    pins_chk("R8 disable pin0", 14'h007E, 14'h0000);
  endtask

  task automatic t_unmapped();
    do_reset();
    rd_chk("R9 gap offset", 6'h0C, 8'h00);
    rd_chk("R9 lo byte past end", 6'h03, 8'h00);
    rd_chk("R9 hi byte past end", 6'h23, 8'h00);
    rd_chk("R9 top gap", 6'h1C, 8'h00);
    wr(6'h05, 8'hFF);
    wr(6'h04, 8'h00);
    rd_chk("R9 bits past count", 6'h05, 8'h03);
    wr(6'h0C, 8'hFF);
    wr(6'h2C, 8'hFF);
    rd_chk("R9 gap write no effect", 6'h00, 8'h7F);
    pins_chk("R9 gap write pins", 14'h007F, 14'h0000);
  endtask

  task automatic t_hold();
    do_reset();
    rd_chk("R10 load", 6'h00, 8'h7F);
    @(negedge clk); addr = 6'h20;
    repeat (3) @(negedge clk);
    chk("R10 hold", {8'h00, rd_data}, 16'h007F);
  endtask

  initial begin
    t_reset();
    t_drive();
    t_sync();
    t_high_bank();
    t_disabled();
    t_unmapped();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule